// File: doc/BRIEF.md
# Wait-State Timing Register Bank

This block holds the delay configuration for a set of external memory regions and turns it into wait-state cycle counts for a bus arbiter. Nine 32-bit configuration registers sit behind a small register bus. Index 8 is the shared delay register. Indices 0 to 7 are per-region delay registers. The bus supports byte-lane writes, and a combinational readback returns the register at the presented index.

Three of the regions are timed: the boot ROM, the disc controller and the sound unit. For each of them the block derives byte, halfword and word access counts from the region's own register and the shared register. The counts are held in output registers. They are reloaded only after a write has changed a stored value. The arbiter uses the counts directly. The block does not decode addresses and does not run the external accesses.

Top module: `wst_timing_bank`

## Requirements
- R1: After reset the registers read back as follows: index 0 = 0x0013243F, 1 = 0x00003022, 2 = 0x0013243F, 3 = 0x200931E1, 4 = 0x00020843, 5 = 0x00070777, 6 = 0, 7 = 0, 8 = 0x00031125. The count outputs are loaded from these values by the first clock edge after the internal reset is released.
- R2: A write with `reg_wr` high changes only the bytes whose `reg_be` bit is set (bit n covers data bits 8n+7:8n). A write with no lane enabled changes nothing.
- R3: Only bits in the write mask can change. The mask is 0x0003FFFF for index 8 and 0xAF1FFFFF for indices 0 to 7. Each masked bit keeps its old value.
- R4: Per-region field layout: access time [7:4], shared-term-0 enable bit 8, minimum enable bit 9, shared-term-2 enable bit 10, 16-bit bus flag bit 12. Shared register layout: term0 [3:0], term2 [11:8], minimum [15:12]. The boot ROM uses index 2, the sound unit index 3 and the disc controller index 4.
- R5: Two counts, lead and follow, start at 0. The term0 enable adds term0-1 to both. The term2 enable adds term2 to both. The minimum enable sets a floor term to the minimum field; without it the floor term is 0.
- R6: A lead count below 6 is incremented by one. Both counts then add the access time plus 2.
- R7: The lead count is raised to at least floor+6, and the follow count to at least floor+2.
- R8: Byte = lead. With the 16-bit flag set: halfword = lead and word = lead+follow. With the flag clear: halfword = lead+follow and word = lead+3*follow. Each output is its value minus 1, floored at 0.
- R9: The count outputs change only at the clock edge after the edge that stored a changed register value. A write that leaves the stored value the same leaves the outputs unchanged.
- R10: Writes to indices 9 to 15 change no register, and reads of those indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_idx | input | 4 | Register index |
| reg_be | input | 4 | Byte-lane enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Readback of the indexed register, 0 out of range |
| boot_cyc_b | output | 8 | Boot ROM byte access count |
| boot_cyc_h | output | 8 | Boot ROM halfword access count |
| boot_cyc_w | output | 8 | Boot ROM word access count |
| disc_cyc_b | output | 8 | Disc controller byte access count |
| disc_cyc_h | output | 8 | Disc controller halfword access count |
| disc_cyc_w | output | 8 | Disc controller word access count |
| snd_cyc_b | output | 8 | Sound unit byte access count |
| snd_cyc_h | output | 8 | Sound unit halfword access count |
| snd_cyc_w | output | 8 | Sound unit word access count |

## Verification
The bench sweeps every combination of the enable flags, the bus width and the access time of the boot ROM register, under several shared settings. It also sweeps the shared term0 and minimum fields against a region with all terms enabled. A term0 of zero drives the lead count negative before the increment. A design that treats the term as unsigned reports counts near 255, and one that skips the floor clamp reports counts too small whenever the minimum exceeds the sum. Byte-lane, masked-bit and out-of-range writes are read back to catch merges that spill into disabled lanes or protected bits. A latency probe catches outputs that update one edge early or keep stale counts.

// File: rtl/wst_pkg.sv
package wst_pkg;

  localparam int REG_W      = 32;
  localparam int NREG       = 9;
  localparam int IDX_W      = 4;
  localparam int BE_W       = REG_W / 8;
  localparam int COMMON_IDX = 8;
  localparam int NTAP       = 3;
  localparam int FLD_W      = 4;
  localparam int CYC_W      = 8;
  localparam int CALC_W     = 10;

  localparam logic [REG_W-1:0] REGION_WMASK = 32'hAF1F_FFFF;
  localparam logic [REG_W-1:0] COMMON_WMASK = 32'h0003_FFFF;

  // per-region field positions
  localparam int ACC_LSB = 4;
  localparam int C0_BIT  = 8;
  localparam int C3_BIT  = 9;
  localparam int C2_BIT  = 10;
  localparam int W16_BIT = 12;
  // shared-register field positions
  localparam int CM0_LSB = 0;
  localparam int CM2_LSB = 8;
  localparam int CM3_LSB = 12;

  typedef struct packed {
    logic [FLD_W-1:0] acc;
    logic             use_c0;
    logic             use_c2;
    logic             use_c3;
    logic             wide;
  } region_f_t;

  typedef struct packed {
    logic [FLD_W-1:0] c0;
    logic [FLD_W-1:0] c2;
    logic [FLD_W-1:0] c3;
  } common_f_t;

  typedef struct packed {
    logic [CYC_W-1:0] b;
    logic [CYC_W-1:0] h;
    logic [CYC_W-1:0] w;
  } cyc_t;

  function automatic logic [REG_W-1:0] reset_word(input int idx);
    case (idx)
      0:       return 32'h0013_243F;
      1:       return 32'h0000_3022;
      2:       return 32'h0013_243F;
      3:       return 32'h2009_31E1;
      4:       return 32'h0002_0843;
      5:       return 32'h0007_0777;
      8:       return 32'h0003_1125;
      default: return '0;
    endcase
  endfunction

  // register slot feeding each timed region: 0 boot ROM, 1 disc, 2 sound
  function automatic int tap_slot(input int t);
    case (t)
      0:       return 2;
      1:       return 4;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/wst_regfile.sv
module wst_regfile
  import wst_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic [BE_W-1:0]      be,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output region_f_t [NTAP-1:0] taps_o,
  output common_f_t            common_o,
  output logic                 upd_o
);

  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [NREG-1:0][REG_W-1:0] regs_d;
  logic [REG_W-1:0]           lane_m;
  logic [REG_W-1:0]           wmask;
  logic [REG_W-1:0]           sel_old;
  logic [REG_W-1:0]           merged;
  logic                       hit;
  logic                       is_common;
  logic                       wr_ok;
  logic                       chg;
  logic                       upd_q;

  always_comb begin
    for (int b = 0; b < BE_W; b++) begin
      lane_m[8*b +: 8] = {8{be[b]}};
    end
  end

  always_comb begin
    hit     = 1'b0;
    sel_old = '0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == IDX_W'(i)) begin
        hit     = 1'b1;
        sel_old = regs_q[i];
      end
    end
    is_common = (idx == IDX_W'(COMMON_IDX));
    wmask     = lane_m & (is_common ? COMMON_WMASK : REGION_WMASK);
    merged    = (sel_old & ~wmask) | (wdata & wmask);
    wr_ok     = wr_en && hit;
    chg       = wr_ok && (merged != sel_old);
    regs_d    = regs_q;
    for (int i = 0; i < NREG; i++) begin
      if (wr_ok && (idx == IDX_W'(i))) regs_d[i] = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= reset_word(i);
      upd_q <= 1'b1;
    end else begin
      if (wr_ok) regs_q <= regs_d;
      upd_q <= chg;
    end
  end

  assign rdata = hit ? sel_old : '0;
  assign upd_o = upd_q;

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam int SLOT = tap_slot(t);
    assign taps_o[t].acc    = regs_q[SLOT][ACC_LSB +: FLD_W];
    assign taps_o[t].use_c0 = regs_q[SLOT][C0_BIT];
    assign taps_o[t].use_c2 = regs_q[SLOT][C2_BIT];
    assign taps_o[t].use_c3 = regs_q[SLOT][C3_BIT];
    assign taps_o[t].wide   = regs_q[SLOT][W16_BIT];
  end

  assign common_o.c0 = regs_q[COMMON_IDX][CM0_LSB +: FLD_W];
  assign common_o.c2 = regs_q[COMMON_IDX][CM2_LSB +: FLD_W];
  assign common_o.c3 = regs_q[COMMON_IDX][CM3_LSB +: FLD_W];

  // R10
  oob_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(idx) >= NREG)) |=> $stable(regs_q));

  // R2
  no_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (be == '0)) |=> $stable(regs_q));

  // R3
  common_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_q[COMMON_IDX] & ~COMMON_WMASK));

endmodule

// File: rtl/wst_calc.sv
module wst_calc
  import wst_pkg::*;
(
  input  region_f_t rf_i,
  input  common_f_t cf_i,
  output cyc_t      cyc_o
);

  localparam logic signed [CALC_W-1:0] ONE = CALC_W'(1);
  localparam logic signed [CALC_W-1:0] TWO = CALC_W'(2);
  localparam logic signed [CALC_W-1:0] SIX = CALC_W'(6);

  function automatic logic signed [CALC_W-1:0] sx(input logic [FLD_W-1:0] f);
    return $signed({{(CALC_W-FLD_W){1'b0}}, f});
  endfunction

  function automatic logic [CYC_W-1:0] dec_floor(input logic signed [CALC_W-1:0] x);
    logic signed [CALC_W-1:0] y;
    y = x - ONE;
    if (x > 0) return CYC_W'(y);
    return '0;
  endfunction

  logic signed [CALC_W-1:0] lead;
  logic signed [CALC_W-1:0] follow;
  logic signed [CALC_W-1:0] floor_t;
  logic signed [CALC_W-1:0] half_v;
  logic signed [CALC_W-1:0] word_v;

  always_comb begin
    lead    = '0;
    follow  = '0;
    floor_t = '0;
    if (rf_i.use_c0) begin
      lead   = lead + sx(cf_i.c0) - ONE;
      follow = follow + sx(cf_i.c0) - ONE;
    end
    if (rf_i.use_c2) begin
      lead   = lead + sx(cf_i.c2);
      follow = follow + sx(cf_i.c2);
    end
    if (rf_i.use_c3) floor_t = sx(cf_i.c3);
    if (lead < SIX) lead = lead + ONE;
    lead   = lead + sx(rf_i.acc) + TWO;
    follow = follow + sx(rf_i.acc) + TWO;
    if (lead < floor_t + SIX) lead = floor_t + SIX;
    if (follow < floor_t + TWO) follow = floor_t + TWO;
    if (rf_i.wide) begin
      half_v = lead;
      word_v = lead + follow;
    end else begin
      half_v = lead + follow;
      word_v = lead + follow + follow + follow;
    end
    cyc_o.b = dec_floor(lead);
    cyc_o.h = dec_floor(half_v);
    cyc_o.w = dec_floor(word_v);
  end

endmodule

// File: rtl/wst_cycreg.sv
module wst_cycreg
  import wst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  cyc_t d_i,
  output cyc_t q_o
);

  cyc_t q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (ld_i) begin
      q_q <= d_i;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/wst_timing_bank.sv
module wst_timing_bank
  import wst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [BE_W-1:0]  reg_be,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [CYC_W-1:0] boot_cyc_b,
  output logic [CYC_W-1:0] boot_cyc_h,
  output logic [CYC_W-1:0] boot_cyc_w,
  output logic [CYC_W-1:0] disc_cyc_b,
  output logic [CYC_W-1:0] disc_cyc_h,
  output logic [CYC_W-1:0] disc_cyc_w,
  output logic [CYC_W-1:0] snd_cyc_b,
  output logic [CYC_W-1:0] snd_cyc_h,
  output logic [CYC_W-1:0] snd_cyc_w
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]    rst_sync_q;
  logic                 rst_i_n;
  region_f_t [NTAP-1:0] taps;
  common_f_t            common_f;
  logic                 upd;
  cyc_t [NTAP-1:0]      cyc_calc;
  cyc_t [NTAP-1:0]      cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[SYNC_N-1];

  wst_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (reg_wr),
    .idx      (reg_idx),
    .be       (reg_be),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .taps_o   (taps),
    .common_o (common_f),
    .upd_o    (upd)
  );

  for (genvar t = 0; t < NTAP; t++) begin : g_rgn
    wst_calc u_calc (
      .rf_i  (taps[t]),
      .cf_i  (common_f),
      .cyc_o (cyc_calc[t])
    );
    wst_cycreg u_out (
      .clk   (clk),
      .rst_n (rst_i_n),
      .ld_i  (upd),
      .d_i   (cyc_calc[t]),
      .q_o   (cyc_q[t])
    );
  end

  assign boot_cyc_b = cyc_q[0].b;
  assign boot_cyc_h = cyc_q[0].h;
  assign boot_cyc_w = cyc_q[0].w;
  assign disc_cyc_b = cyc_q[1].b;
  assign disc_cyc_h = cyc_q[1].h;
  assign disc_cyc_w = cyc_q[1].w;
  assign snd_cyc_b  = cyc_q[2].b;
  assign snd_cyc_h  = cyc_q[2].h;
  assign snd_cyc_w  = cyc_q[2].w;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !upd |=> $stable(cyc_q));

  // R8
  size_order_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (boot_cyc_b <= boot_cyc_h) && (boot_cyc_h <= boot_cyc_w) &&
    (snd_cyc_b <= snd_cyc_h) && (snd_cyc_h <= snd_cyc_w));

  // R7
  lead_floor_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !upd |-> ((boot_cyc_b >= CYC_W'(5)) && (disc_cyc_b >= CYC_W'(5)) &&
              (snd_cyc_b >= CYC_W'(5))));

endmodule

// File: tb/wst_timing_bank_test.sv
`timescale 1ns/1ps
module wst_timing_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  boot_cyc_b, boot_cyc_h, boot_cyc_w;
  logic [7:0]  disc_cyc_b, disc_cyc_h, disc_cyc_w;
  logic [7:0]  snd_cyc_b, snd_cyc_h, snd_cyc_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] mdl [9];

  always #10 clk = ~clk;

  wst_timing_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .boot_cyc_b(boot_cyc_b), .boot_cyc_h(boot_cyc_h), .boot_cyc_w(boot_cyc_w),
    .disc_cyc_b(disc_cyc_b), .disc_cyc_h(disc_cyc_h), .disc_cyc_w(disc_cyc_w),
    .snd_cyc_b(snd_cyc_b), .snd_cyc_h(snd_cyc_h), .snd_cyc_w(snd_cyc_w)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rst_val(input int i);
    case (i)
      0: return 32'h0013243F;  1: return 32'h00003022;
      2: return 32'h0013243F;  3: return 32'h200931E1;
      4: return 32'h00020843;  5: return 32'h00070777;
      8: return 32'h00031125;
      default: return 32'h0;
    endcase
  endfunction

  // R4 R5 R6 R7 R8: expected counts
  task automatic expc(input logic [31:0] r, input logic [31:0] c,
                      output int b, output int h, output int w);
    int f, s, m, acc, c0, c2, c3;
    acc = int'(r[7:4]); c0 = int'(c[3:0]); c2 = int'(c[11:8]); c3 = int'(c[15:12]);
    f = 0; s = 0; m = 0;
    if (r[8])  begin f = f + c0 - 1; s = s + c0 - 1; end
    if (r[10]) begin f = f + c2;     s = s + c2;     end
    if (r[9])  m = c3;
    if (f < 6) f = f + 1;
    f = f + acc + 2; s = s + acc + 2;
    if (f < m + 6) f = m + 6;
    if (s < m + 2) s = m + 2;
    b = f;
    if (r[12]) begin h = f; w = f + s; end
    else       begin h = f + s; w = f + 3 * s; end
    b = (b > 0) ? b - 1 : 0;
    h = (h > 0) ? h - 1 : 0;
    w = (w > 0) ? w - 1 : 0;
  endtask

  task automatic check_outs(input string req);
    int b, h, w;
    expc(mdl[2], mdl[8], b, h, w);
    chk({req, " boot byte"}, int'(boot_cyc_b), b);
    chk({req, " boot half"}, int'(boot_cyc_h), h);
    chk({req, " boot word"}, int'(boot_cyc_w), w);
    expc(mdl[4], mdl[8], b, h, w);
    chk({req, " disc byte"}, int'(disc_cyc_b), b);
    chk({req, " disc half"}, int'(disc_cyc_h), h);
    chk({req, " disc word"}, int'(disc_cyc_w), w);
    expc(mdl[3], mdl[8], b, h, w);
    chk({req, " snd byte"}, int'(snd_cyc_b), b);
    chk({req, " snd half"}, int'(snd_cyc_h), h);
    chk({req, " snd word"}, int'(snd_cyc_w), w);
  endtask

  // R2 R3 R10: model merge
  task automatic mdl_write(input int i, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m;
    if (i > 8) return;
    m = (i == 8) ? 32'h0003FFFF : 32'hAF1FFFFF;
    for (int k = 0; k < 4; k++) if (!be[k]) m[8*k +: 8] = 8'h00;
    mdl[i] = (mdl[i] & ~m) | (d & m);
  endtask

  task automatic drive_wr(input int i, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 4'(i); reg_be = be; reg_wdata = d;
    mdl_write(i, be, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input int i, input logic [3:0] be, input logic [31:0] d);
    drive_wr(i, be, d);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input int i, input logic [31:0] exp);
    reg_idx = 4'(i);
    #2;
    chk(req, int'(reg_rdata), int'(exp));
  endtask

  initial begin
    int ob, oh, ow;
    logic [31:0] rv;
    for (int i = 0; i < 9; i++) mdl[i] = rst_val(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset readback and outputs
    for (int i = 0; i < 9; i++) rd_chk("R1 reset readback", i, rst_val(i));
    chk("R1 boot word at reset", int'(boot_cyc_w), 24);
    chk("R1 snd word at reset", int'(snd_cyc_w), 40);
    check_outs("R1");

    // R9 latency: disc goes to 16-bit bus
    ob = int'(disc_cyc_w);
    drive_wr(4, 4'hF, 32'h00021843);
    chk("R9 disc word one edge after write", int'(disc_cyc_w), ob);
    @(negedge clk);
    chk("R9 disc word two edges after write", int'(disc_cyc_w), 12);
    check_outs("R9");
    // R9 unchanged write keeps outputs
    wr(4, 4'hF, 32'h00021843);
    check_outs("R9 same-value write");

    // R10 out-of-range writes and reads
    wr(9, 4'hF, 32'hFFFFFFFF);
    wr(15, 4'hF, 32'hFFFFFFFF);
    for (int i = 0; i < 9; i++) rd_chk("R10 regs untouched", i, mdl[i]);
    rd_chk("R10 read idx 9", 9, 32'h0);
    rd_chk("R10 read idx 15", 15, 32'h0);
    check_outs("R10");

    // R2 byte lanes
    wr(8, 4'h0, 32'hFFFFFFFF);
    rd_chk("R2 no lanes", 8, 32'h00031125);
    wr(8, 4'h1, 32'hFFFFFFFF);
    rd_chk("R2 lane0 only", 8, 32'h000311FF);
    check_outs("R2");
    wr(3, 4'h4, 32'h00FF0000);
    rd_chk("R2 lane2 only", 3, 32'h201F31E1);

    // R3 write masks
    wr(0, 4'hF, 32'hFFFFFFFF);
    rd_chk("R3 region mask", 0, 32'hAF1FFFFF);
    wr(8, 4'hF, 32'hFFFFFFFF);
    rd_chk("R3 common mask", 8, 32'h0003FFFF);
    check_outs("R3");
    wr(8, 4'hF, 32'h00000000);
    rd_chk("R3 common cleared", 8, 32'h0);
    check_outs("R3 zero common");

    // R4 R5 R6 R7 R8 boot sweep under three shared settings
    for (int cs = 0; cs < 3; cs++) begin
      wr(8, 4'hF, (cs == 0) ? 32'h00009203 : (cs == 1) ? 32'h00000F00 : 32'h0000F0F1);
      for (int v = 0; v < 256; v++) begin
        rv = mdl[2] & ~32'h000017F0;
        rv = rv | (32'(v & 15) << 4) | (32'((v >> 4) & 1) << 8) |
             (32'((v >> 5) & 1) << 9) | (32'((v >> 6) & 1) << 10) |
             (32'((v >> 7) & 1) << 12);
        wr(2, 4'hF, rv);
        check_outs("R5 R6 R7 R8 boot sweep");
      end
    end

    // R4 R5 R7 shared sweep with all terms on for sound, term0 only for boot
    wr(3, 4'hF, 32'h00000750);
    wr(2, 4'hF, 32'h00001130);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        wr(8, 4'hF, (32'(j) << 12) | (32'((i * 7 + j) & 15) << 8) | 32'(i));
        check_outs("R4 R5 R7 shared sweep");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule